// File: doc/BRIEF.md
# Flash Prewrite Program-Verify Sequencer

This block walks a byte-wide flash array through its prewrite pass, which runs ahead of a block erase. On a start command it marks the chosen block in a one-hot block-select register. It then visits every address from the start address up to the last address. At each address it latches a zero byte with one write strobe and applies a program pulse inside an armed watchdog window. After a settling delay it reads the byte back. A byte that still reads nonzero gets another write and a pulse of twice the previous length. After the sixth failed attempt the sequencer gives up and flags an error.

All delays are counted in clock cycles. The first pulse length comes from an input, and the settling delay comes from a parameter. The watchdog overflow value is presented as a fixed output for the watchdog to load. The flash cells, the programming supply and the erase step itself sit outside this block.

Top module: `flash_prewrite_seq`

## Requirements
- R1: An accepted start sets `blk_reg_o` to the one-hot value `1 << blk_sel_i`. A pass that finishes successfully clears the register in the cycle `done_o` is high. A pass that ends in error leaves the bit set.
- R2: Before every program pulse, exactly one write strobe (`we_o`=1, `wdata_o`=0x00) occurs at the current `addr_o`. It comes two cycles before `prog_o` rises.
- R3: `wdt_en_o` rises one cycle before `prog_o` rises. It stays high for one cycle after `prog_o` falls and is low otherwise. `wdt_load_o` always reads 0xFE.
- R4: Attempt n at an address drives `prog_o` high for exactly `init_pulse_i << (n-1)` cycles.
- R5: After `prog_o` falls, `verify_o` pulses for one cycle exactly `SETTLE_CYC+1` cycles later. While it is high, `prog_o`, `we_o` and `wdt_en_o` are low. A byte passes verify only when `rdata_i` is 0x00.
- R6: After a pass, the sequencer moves to `addr_o+1` unless the current address equals `last_addr_i`, in which case the prewrite ends. Each attempt takes pulse length + `SETTLE_CYC` + 4 cycles. `done_o` is high in the cycle after the final verify.
- R7: If verify fails on attempt `MAX_TRY` (6), the pass ends with `error_o`=1 and `addr_o` held at the failing address.
- R8: `done_o` is high for exactly one cycle at the end of every pass. `error_o` stays as set until the next accepted start clears it.
- R9: A start command while a pass is running has no effect on `blk_reg_o` or on the pass timing.
- R10: After reset, `done_o`, `error_o`, `prog_o`, `we_o`, `verify_o`, `wdt_en_o` and `blk_reg_o` are all 0. A reset during a pass returns all of them to 0.
- R11: Each new address restarts at attempt 1 with the initial pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a prewrite pass (accepted when idle) |
| blk_sel_i | input | $clog2(NUM_BLK) | Index of the block to prewrite |
| start_addr_i | input | ADDR_W | First address of the block |
| last_addr_i | input | ADDR_W | Last address of the block |
| init_pulse_i | input | PULSE_W | First program pulse length in cycles |
| rdata_i | input | DATA_W | Flash read data |
| addr_o | output | ADDR_W | Flash address |
| wdata_o | output | DATA_W | Flash write data (always zero) |
| we_o | output | 1 | Byte write strobe |
| prog_o | output | 1 | Program mode control |
| verify_o | output | 1 | Prewrite verify read strobe |
| wdt_en_o | output | 1 | Watchdog enable |
| wdt_load_o | output | 8 | Watchdog overflow counter value |
| blk_reg_o | output | NUM_BLK | Block-select register |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| error_o | output | 1 | Prewrite failed; held until next start |

## Verification
The assertions assume the following about the inputs:
- `init_pulse_i` is at least 1 and stays stable for the whole pass.
- `last_addr_i` is not below `start_addr_i`.
- `rdata_i` reflects the byte at `addr_o` in the verify cycle.

The stimulus meets these assumptions. It holds the address and pulse inputs constant through each pass and picks only ranges with the last address at or above the start. A memory stub that answers combinationally counts the program pulses each address has received, and it reads zero only once an address has seen its required number of pulses. The one start pulse sent mid-pass is the deliberate busy-start case.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_ARM, S_PROG, S_DISARM, S_SETTLE, S_VERIFY, S_END
  } prw_state_e;
endpackage

// File: rtl/prw_timer.sv
module prw_timer #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // <=1 so a zero load cannot hang the sequencer
  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/prw_try_ctl.sv
module prw_try_ctl #(
  parameter int PULSE_W = 8,
  parameter int MAX_TRY = 6,
  localparam int LEN_W  = PULSE_W + MAX_TRY - 1,
  localparam int TRY_W  = $clog2(MAX_TRY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               retry_i,
  input  logic [PULSE_W-1:0] init_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               last_try_o
);
  logic [TRY_W-1:0] try_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      try_q <= TRY_W'(1);
      len_q <= '0;
    end else if (restart_i) begin
      try_q <= TRY_W'(1);
      len_q <= LEN_W'(init_i);
    end else if (retry_i) begin
      try_q <= try_q + 1'b1;
      len_q <= len_q << 1;
    end
  end

  assign len_o      = len_q;
  assign last_try_o = (try_q >= TRY_W'(MAX_TRY));
endmodule

// File: rtl/prw_addr_ctr.sv
module prw_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= first_i;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o    = addr_q;
  assign at_last_o = (addr_q == last_i);
endmodule

// File: rtl/flash_prewrite_seq.sv
module flash_prewrite_seq
  import prw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_BLK    = 4,
  parameter int PULSE_W    = 8,
  parameter int MAX_TRY    = 6,
  parameter int SETTLE_CYC = 1000,
  parameter logic [7:0] WDT_LOAD = 8'hFE,
  localparam int SEL_W = $clog2(NUM_BLK),
  localparam int LEN_W = PULSE_W + MAX_TRY - 1,
  localparam int SET_W = $clog2(SETTLE_CYC + 1),
  localparam int TMR_W = (LEN_W > SET_W) ? LEN_W : SET_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   blk_sel_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic [ADDR_W-1:0]  last_addr_i,
  input  logic [PULSE_W-1:0] init_pulse_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               prog_o,
  output logic               verify_o,
  output logic               wdt_en_o,
  output logic [7:0]         wdt_load_o,
  output logic [NUM_BLK-1:0] blk_reg_o,
  output logic               done_o,
  output logic               error_o
);
  prw_state_e state_q, state_d;
  logic [NUM_BLK-1:0] blk_q;
  logic err_q;
  logic accept, pass, at_last, last_try, tmr_last;
  logic [LEN_W-1:0] len;
  logic tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic addr_inc, restart, retry, fin_ok, fin_err;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign pass     = (rdata_i == '0);
  assign fin_ok   = (state_q == S_VERIFY) && pass && at_last;
  assign fin_err  = (state_q == S_VERIFY) && !pass && last_try;
  assign addr_inc = (state_q == S_VERIFY) && pass && !at_last;
  assign restart  = accept || addr_inc;
  assign retry    = (state_q == S_VERIFY) && !pass && !last_try;
  assign tmr_load = (state_q == S_ARM) || (state_q == S_DISARM);
  assign tmr_val  = (state_q == S_ARM) ? TMR_W'(len) : TMR_W'(SETTLE_CYC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_WRITE;
      S_WRITE:  state_d = S_ARM;
      S_ARM:    state_d = S_PROG;
      S_PROG:   if (tmr_last) state_d = S_DISARM;
      S_DISARM: state_d = S_SETTLE;
      S_SETTLE: if (tmr_last) state_d = S_VERIFY;
      S_VERIFY: state_d = (fin_ok || fin_err) ? S_END : S_WRITE;
      S_END:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        blk_q <= NUM_BLK'(1) << blk_sel_i;
        err_q <= 1'b0;
      end else begin
        if (fin_ok)  blk_q <= '0;
        if (fin_err) err_q <= 1'b1;
      end
    end
  end

  prw_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(accept), .inc_i(addr_inc),
    .first_i(start_addr_i), .last_i(last_addr_i),
    .addr_o, .at_last_o(at_last)
  );

  prw_try_ctl #(.PULSE_W(PULSE_W), .MAX_TRY(MAX_TRY)) u_try (
    .clk_i, .rst_ni,
    .restart_i(restart), .retry_i(retry), .init_i(init_pulse_i),
    .len_o(len), .last_try_o(last_try)
  );

  prw_timer #(.W(TMR_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .val_i(tmr_val), .last_o(tmr_last)
  );

  assign wdata_o    = '0;
  assign we_o       = (state_q == S_WRITE);
  assign prog_o     = (state_q == S_PROG);
  assign verify_o   = (state_q == S_VERIFY);
  assign wdt_en_o   = (state_q == S_ARM) || (state_q == S_PROG) || (state_q == S_DISARM);
  assign wdt_load_o = WDT_LOAD;
  assign blk_reg_o  = blk_q;
  assign done_o     = (state_q == S_END);
  assign error_o    = err_q;
endmodule

// File: rtl/prw_checker.sv
module prw_checker #(
  parameter int NUM_BLK = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               we_o,
  input logic               prog_o,
  input logic               verify_o,
  input logic               wdt_en_o,
  input logic               done_o,
  input logic               error_o,
  input logic [NUM_BLK-1:0] blk_reg_o
);
  assert_blk_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o) |-> (blk_reg_o == '0));

  assert_write_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(we_o, 2));

  assert_wdt_cover_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> wdt_en_o);

  assert_wdt_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(wdt_en_o));

  assert_wdt_after_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_o) |-> wdt_en_o);

  assert_verify_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verify_o |-> (!prog_o && !we_o && !wdt_en_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);
endmodule

bind flash_prewrite_seq prw_checker #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .we_o(we_o),
  .prog_o(prog_o), .verify_o(verify_o), .wdt_en_o(wdt_en_o),
  .done_o(done_o), .error_o(error_o), .blk_reg_o(blk_reg_o)
);

// File: tb/flash_prewrite_seq_tb.sv
`timescale 1ns/1ps
module flash_prewrite_seq_tb;
  localparam int S = 6;
  localparam int NT = 6;

  typedef struct packed {
    logic [7:0] sa;
    logic [7:0] la;
    logic [7:0] init;
    logic [1:0] sel;
    logic [7:0] hard;
    logic [3:0] need;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h10, 8'h13, 8'd3, 2'd0, 8'h11, 4'd2},
    '{8'h20, 8'h20, 8'd1, 2'd1, 8'h20, 4'd6},
    '{8'h30, 8'h32, 8'd2, 2'd2, 8'h31, 4'd7},
    '{8'hFE, 8'hFF, 8'd5, 2'd3, 8'h00, 4'd1},
    '{8'h40, 8'h45, 8'd4, 2'd1, 8'h45, 4'd3},
    '{8'h50, 8'h50, 8'd2, 2'd0, 8'h50, 4'd1}
  };

  logic clk = 0, rst_ni = 0, start_i = 0;
  logic [1:0] blk_sel_i = 0;
  logic [7:0] start_addr_i = 0, last_addr_i = 0, init_pulse_i = 1;
  logic [7:0] rdata_i, addr_o, wdata_o, wdt_load_o;
  logic we_o, prog_o, verify_o, wdt_en_o, done_o, error_o;
  logic [3:0] blk_reg_o;

  int n_chk = 0, n_fail = 0;
  int pcount [256];
  int need_arr [256];
  int init_cur = 1;

  always #2 clk = ~clk;

  flash_prewrite_seq #(.SETTLE_CYC(S)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .blk_sel_i, .start_addr_i, .last_addr_i,
    .init_pulse_i, .rdata_i, .addr_o, .wdata_o, .we_o, .prog_o, .verify_o,
    .wdt_en_o, .wdt_load_o, .blk_reg_o, .done_o, .error_o
  );

  assign rdata_i = (pcount[addr_o] >= need_arr[addr_o]) ? 8'h00 : 8'h5A;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor and memory stub bookkeeping
  logic prev_prog = 0, prev_wdt = 0, wrote = 0;
  logic [7:0] wr_addr = 0;
  int plen = 0, since_fall = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_prog <= 0; prev_wdt <= 0; wrote <= 0; plen <= 0;
    end else begin
      if (we_o) begin
        wrote <= (wdata_o == 8'h00);
        wr_addr <= addr_o;
      end
      if (prog_o && !prev_prog) begin
        check(prev_wdt, "R3 wdt armed before pulse", prev_wdt, 1);
        check(wrote && wr_addr == addr_o, "R2 zero write before pulse", wrote, 1);
        plen <= 1;
      end else if (prog_o) plen <= plen + 1;
      if (!prog_o && prev_prog) begin
        check(wdt_en_o, "R3 wdt held after pulse", wdt_en_o, 1);
        check(plen == (init_cur << pcount[addr_o]), "R4 R11 pulse length",
              plen, init_cur << pcount[addr_o]);
        pcount[addr_o] = pcount[addr_o] + 1;
        wrote <= 0;
        since_fall <= 1;
      end else if (!prog_o) since_fall <= since_fall + 1;
      if (verify_o)
        check(since_fall == S + 1 && !we_o && !wdt_en_o, "R5 settle and quiet verify",
              since_fall, S + 1);
      prev_prog <= prog_o;
      prev_wdt  <= wdt_en_o;
    end
  end

  task automatic run_vec(input int vi);
    vec_t v = VEC[vi];
    int t = 0, c = 0, m;
    bit err = 0;
    bit prev_err = error_o;
    for (int a = 0; a < 256; a++) begin pcount[a] = 0; need_arr[a] = 1; end
    need_arr[v.hard] = int'(v.need);
    init_cur = int'(v.init);
    for (int a = int'(v.sa); a <= int'(v.la); a++) begin
      m = (a == int'(v.hard)) ? int'(v.need) : 1;
      if (m > NT) begin m = NT; err = 1; end
      for (int k = 0; k < m; k++) t += (int'(v.init) << k) + S + 4;
      if (err) break;
    end
    @(negedge clk);
    check(error_o == prev_err, "R8 error held while idle", error_o, prev_err);
    start_addr_i = v.sa; last_addr_i = v.la; init_pulse_i = v.init; blk_sel_i = v.sel;
    start_i = 1;
    while (1) begin
      @(negedge clk);
      c++;
      start_i = 0;
      if (c == 1) begin
        check(blk_reg_o == (4'b1 << v.sel), "R1 block bit set", blk_reg_o, 4'b1 << v.sel);
        check(!error_o, "R8 error cleared at start", error_o, 0);
      end
      if (vi == 4 && c == 10) begin blk_sel_i = 2'd3; start_i = 1; end
      if (vi == 4 && c == 12)
        check(blk_reg_o == (4'b1 << v.sel), "R9 busy start ignored", blk_reg_o, 4'b1 << v.sel);
      if (done_o || c > 5000) break;
    end
    check(c == t + 1, "R6 R7 pass duration", c, t + 1);
    check(error_o == err, "R7 error flag", error_o, err);
    check(blk_reg_o == (err ? (4'b1 << v.sel) : 4'b0), "R1 block register at end",
          blk_reg_o, err ? (4'b1 << v.sel) : 0);
    if (err) check(addr_o == v.hard, "R7 failing address held", addr_o, v.hard);
    else     check(addr_o == v.la, "R6 stops at last address", addr_o, v.la);
    @(negedge clk);
    check(!done_o, "R8 done one cycle", done_o, 0);
    check(error_o == err, "R8 error held after done", error_o, err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin pcount[a] = 0; need_arr[a] = 1; end
    repeat (3) @(negedge clk);
    check({done_o, error_o, prog_o, we_o, verify_o, wdt_en_o} == 6'b0, "R10 reset outputs",
          {done_o, error_o, prog_o, we_o, verify_o, wdt_en_o}, 0);
    check(blk_reg_o == 4'b0, "R10 reset block register", blk_reg_o, 0);
    rst_ni = 1;
    @(negedge clk);
    check(wdt_load_o == 8'hFE, "R3 watchdog load value", wdt_load_o, 8'hFE);
    for (int vi = 0; vi < 6; vi++) run_vec(vi);
    // reset in the middle of a pass
    start_addr_i = 8'h60; last_addr_i = 8'h68; init_pulse_i = 8'd8; blk_sel_i = 2'd2;
    start_i = 1;
    repeat (6) @(negedge clk);
    start_i = 0;
    check(prog_o && blk_reg_o == 4'b0100, "R10 pass running before reset", prog_o, 1);
    rst_ni = 0;
    @(negedge clk);
    check({prog_o, wdt_en_o, we_o, done_o, error_o} == 5'b0 && blk_reg_o == 4'b0,
          "R10 reset mid-pass", blk_reg_o, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check(!prog_o && !we_o, "R10 idle after reset", prog_o, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule